// File: doc/BRIEF.md
# SPARKLE256 Iterative Permutation Core

This core applies the 256-bit SPARKLE permutation to a state of eight 32-bit words. The words form four branches, each an (x, y) pair. A single-cycle start strobe captures the input state and a requested step count. After that the core computes one complete step per clock cycle. Each step first folds the step counter and a cyclic round constant into the left branch, then runs an ARX-box on every branch, and then mixes the branches through a Feistel-style linear layer with a branch permutation.

When the last step is done, the result is written to a registered output and a one-cycle done pulse is raised. The output then holds that value until the next operation completes. A busy flag covers the cycles in which steps are being computed. Starts that arrive during those cycles are dropped.

Top module: `sparkle256_core`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, busy_o and done_o are 0 and state_o is all zeros.
- R2: Word k of state_i and state_o occupies bits [32k+31:32k]. The words in ascending k are x0, y0, x1, y1, x2, y2, x3, y3, and branch b is (word 2b, word 2b+1).
- R3: At the start of step c (c = 0, 1, ...), y1 is XORed with c and y0 is XORed with constant number (c mod 8). The constants, numbers 0 to 7, are B7E15162, BF715880, 38B4DA56, 324E7738, BB1185EB, 4F7C7B57, CFBFA1C8, C2B3293D (hex).
- R4: The ARX-box of branch b always uses constant number b. It performs four rounds, each of the form x += rotr(y,a); y ^= rotr(x,r); x ^= const. The (a, r) pairs, in round order, are (31,24), (17,17), (0,31), (24,16).
- R5: In the linear layer, u = rotr(t ^ (t<<16), 16) with t = x0^x1, and v is formed the same way from y0^y1. Let y2' = y2^u, y3' = y3^u, x2' = x2^v and x3' = x3^v. The new words are y0 = y3'^y1, y1 = y2'^y0, y2 = y0 and y3 = y1, and the x words follow the same pattern.
- R6: A start accepted with step count N (1 to 15) makes done_o high for exactly one cycle, N cycles after the accepting edge. In that same cycle state_o shows the state after N steps.
- R7: busy_o is high from the cycle after an accepted non-zero start until done_o rises, and it is never high together with done_o. A start while busy_o is high is ignored.
- R8: A start with step count 0 raises done_o on the next cycle and shows state_i unchanged on state_o.
- R9: state_o changes only in a cycle where done_o is high, and it holds its value at all other times.
- R10: The step counter runs from 0 to N-1 within one operation, so runs longer than 8 steps reuse the constants cyclically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted while not busy |
| steps_i | input | 4 | Number of steps to apply |
| state_i | input | 256 | Input state, word packing per R2 |
| busy_o | output | 1 | Steps in progress |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 256 | Registered result state |

## Verification
A completion and a new start can fall in the same cycle. The bench provokes this by raising start_i in the very cycle in which done_o is high, and the new operation must then be accepted because busy_o has already dropped. A start in the last busy cycle, by contrast, must be dropped. A cycle-level behavioural model follows the start, busy and done timing and recomputes every step from the written rules. On every clock its busy, done and output values are compared with the core's.

// File: rtl/sparkle_pkg.sv
// Package: shared types, the round constant source and a rotate helper for
// the permutation core. Assumes 32-bit words and four branches.
package sparkle_pkg;

    localparam int WORD_W   = 32;
    localparam int N_BRANCH = 4;
    localparam int N_WORDS  = 2 * N_BRANCH;
    localparam int RC_IDX_W = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

    // Round constant selected by a 3-bit index.
    function automatic word_t round_const(input logic [RC_IDX_W-1:0] idx);
        unique case (idx)
            3'd0: return 32'hB7E15162;
            3'd1: return 32'hBF715880;
            3'd2: return 32'h38B4DA56;
            3'd3: return 32'h324E7738;
            3'd4: return 32'hBB1185EB;
            3'd5: return 32'h4F7C7B57;
            3'd6: return 32'hCFBFA1C8;
            default: return 32'hC2B3293D;
        endcase
    endfunction

    // Right rotation by a fixed amount in 1..31.
    function automatic word_t rotr(input word_t v, input int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    // Linear layer mixing function: rotate right by 16 of t ^ (t << 16).
    function automatic word_t ell(input word_t t);
        word_t m;
        m = t ^ (t << 16);
        return rotr(m, 16);
    endfunction

endpackage

// File: rtl/sparkle_arx_box.sv
// ARX-box: four add/rotate/xor rounds on one (x, y) branch using a single
// branch constant. Purely combinational; constant supplied by the parent.
module sparkle_arx_box
    import sparkle_pkg::*;
(
    input  word_t x_i,
    input  word_t y_i,
    input  word_t c_i,
    output word_t x_o,
    output word_t y_o
);

    word_t x1, y1, x2, y2, x3, y3, x4, y4;

    // Four unrolled rounds; rotation pairs are fixed by the algorithm.
    always_comb begin
        x1 = (x_i + rotr(y_i, 31));
        y1 = y_i ^ rotr(x1, 24);
        x1 = x1 ^ c_i;

        x2 = (x1 + rotr(y1, 17));
        y2 = y1 ^ rotr(x2, 17);
        x2 = x2 ^ c_i;

        x3 = x2 + y2;
        y3 = y2 ^ rotr(x3, 31);
        x3 = x3 ^ c_i;

        x4 = (x3 + rotr(y3, 24));
        y4 = y3 ^ rotr(x4, 16);
        x4 = x4 ^ c_i;
    end

    assign x_o = x4;
    assign y_o = y4;

endmodule

// File: rtl/sparkle_linear.sv
// Linear layer: Feistel mix of the left half into the right half followed by
// a one-branch rotation of the right half and a left/right swap.
// Combinational; assumes four branches packed as in sparkle_pkg::state_t.
module sparkle_linear
    import sparkle_pkg::*;
(
    input  state_t s_i,
    output state_t s_o
);

    word_t u, v;
    word_t x2m, x3m, y2m, y3m;

    // Feistel contributions from the left branches.
    always_comb begin
        u   = ell(s_i[0] ^ s_i[2]);   // from x0 ^ x1
        v   = ell(s_i[1] ^ s_i[3]);   // from y0 ^ y1
        x2m = s_i[4] ^ v;
        x3m = s_i[6] ^ v;
        y2m = s_i[5] ^ u;
        y3m = s_i[7] ^ u;
    end

    // Branch permutation with swap of halves.
    always_comb begin
        s_o[0] = x3m ^ s_i[2];
        s_o[1] = y3m ^ s_i[3];
        s_o[2] = x2m ^ s_i[0];
        s_o[3] = y2m ^ s_i[1];
        s_o[4] = s_i[0];
        s_o[5] = s_i[1];
        s_o[6] = s_i[2];
        s_o[7] = s_i[3];
    end

endmodule

// File: rtl/sparkle_step.sv
// One full permutation step: counter/constant injection, ARX layer on all
// branches, then the linear layer. Combinational; assumes CNT_W >= 3.
module sparkle_step
    import sparkle_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  state_t           s_i,
    input  logic [CNT_W-1:0] cnt_i,
    output state_t           s_o
);

    state_t inj, arx;

    // Fold the step counter into y1 and the cyclic constant into y0.
    always_comb begin
        inj    = s_i;
        inj[1] = s_i[1] ^ round_const(cnt_i[RC_IDX_W-1:0]);
        inj[3] = s_i[3] ^ {{(WORD_W-CNT_W){1'b0}}, cnt_i};
    end

    // One ARX-box per branch, constant fixed by branch position.
    for (genvar b = 0; b < N_BRANCH; b++) begin : g_branch
        sparkle_arx_box u_box (
            .x_i (inj[2*b]),
            .y_i (inj[2*b+1]),
            .c_i (round_const(RC_IDX_W'(b))),
            .x_o (arx[2*b]),
            .y_o (arx[2*b+1])
        );
    end

    sparkle_linear u_lin (
        .s_i (arx),
        .s_o (s_o)
    );

endmodule

// File: rtl/sparkle256_core.sv
// Iterative SPARKLE256 core: accepts a start with a state and step count,
// computes one step per cycle, then registers the result and pulses done.
// Starts during busy are dropped. Synchronous active-low reset.
module sparkle256_core
    import sparkle_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [CNT_W-1:0]          steps_i,
    input  logic [N_WORDS*WORD_W-1:0] state_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [N_WORDS*WORD_W-1:0] state_o
);

    logic             busy_q, done_q;
    logic [CNT_W-1:0] cnt_q, tgt_q;
    logic [CNT_W-1:0] cnt_nxt;
    state_t           work_q, out_q, step_s;
    logic             accept, zero_req, last_step;

    assign accept    = start_i && !busy_q;
    assign zero_req  = (steps_i == '0);
    assign cnt_nxt   = cnt_q + 1'b1;
    assign last_step = busy_q && (cnt_nxt == tgt_q);

    sparkle_step #(.CNT_W(CNT_W)) u_step (
        .s_i   (work_q),
        .cnt_i (cnt_q),
        .s_o   (step_s)
    );

    // Control: busy flag, done pulse, step counter and target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            tgt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cnt_q  <= '0;
                tgt_q  <= steps_i;
                busy_q <= !zero_req;
                done_q <= zero_req;
            end else if (busy_q) begin
                cnt_q <= cnt_nxt;
                if (last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Working state: loaded on accept, advanced one step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (accept) begin
            work_q <= state_i;
        end else if (busy_q) begin
            work_q <= step_s;
        end
    end

    // Result register: written only when an operation completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (accept && zero_req) begin
            out_q <= state_i;
        end else if (last_step) begin
            out_q <= step_s;
        end
    end

    assign busy_o  = busy_q;
    assign done_o  = done_q;
    assign state_o = out_q;

endmodule

// File: rtl/sparkle256_core_chk.sv
// Checker for sparkle256_core: handshake timing, latency and output
// stability. Attached to every instance through bind.
module sparkle256_core_chk #(
    parameter int CNT_W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [CNT_W-1:0] steps_i,
    input logic [255:0]   state_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [255:0]   state_o
);

    logic [CNT_W-1:0] lat_cnt, lat_tgt;

    // Independent count of busy cycles since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            lat_tgt <= '0;
        end else if (start_i && !busy_o) begin
            lat_cnt <= '0;
            lat_tgt <= steps_i;
        end else if (busy_o) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    AST_NO_BUSY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R7

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && steps_i != '0) |=> busy_o); // R7

    AST_ZERO_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && steps_i == '0) |=> (done_o && state_o == $past(state_i))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(start_i && steps_i == '0)) |=> !done_o); // R6

    AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && lat_cnt == lat_tgt)); // R6

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(state_o)); // R9

endmodule

bind sparkle256_core sparkle256_core_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sparkle256_core_test.sv
// Bench for sparkle256_core: behavioural cycle model compared every clock,
// plus directed checks on reset, zero steps, overlap and stability.
module sparkle256_core_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [3:0]   steps_i = '0;
    logic [255:0] state_i = '0;
    logic         busy_o, done_o;
    logic [255:0] state_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    sparkle256_core uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .steps_i(steps_i),
        .state_i(state_i), .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
    );

    localparam logic [31:0] RC [8] = '{32'hB7E15162, 32'hBF715880, 32'h38B4DA56,
        32'h324E7738, 32'hBB1185EB, 32'h4F7C7B57, 32'hCFBFA1C8, 32'hC2B3293D};
    localparam int ROT_A [4] = '{31, 17, 0, 24};
    localparam int ROT_B [4] = '{24, 17, 31, 16};

    function automatic logic [31:0] ror(input logic [31:0] v, input int n);
        if (n == 0) return v;
        return (v >> n) | (v << (32 - n));
    endfunction

    // Reference step built from the written rules (R2 to R5).
    function automatic logic [255:0] ref_step(input logic [255:0] s, input int k);
        logic [31:0] x [4];
        logic [31:0] y [4];
        logic [31:0] t, u, v, x2p, x3p, y2p, y3p;
        logic [255:0] r;
        for (int i = 0; i < 4; i++) begin
            x[i] = s[64*i +: 32];
            y[i] = s[64*i+32 +: 32];
        end
        y[1] = y[1] ^ 32'(k);
        y[0] = y[0] ^ RC[k % 8];
        for (int b = 0; b < 4; b++) begin
            for (int j = 0; j < 4; j++) begin
                x[b] = x[b] + ror(y[b], ROT_A[j]);
                y[b] = y[b] ^ ror(x[b], ROT_B[j]);
                x[b] = x[b] ^ RC[b];
            end
        end
        t = x[0] ^ x[1]; t = t ^ (t << 16); u = ror(t, 16);
        t = y[0] ^ y[1]; t = t ^ (t << 16); v = ror(t, 16);
        y2p = y[2] ^ u; y3p = y[3] ^ u;
        x2p = x[2] ^ v; x3p = x[3] ^ v;
        r[31:0]    = x3p ^ x[1];
        r[63:32]   = y3p ^ y[1];
        r[95:64]   = x2p ^ x[0];
        r[127:96]  = y2p ^ y[0];
        r[159:128] = x[0];
        r[191:160] = y[0];
        r[223:192] = x[1];
        r[255:224] = y[1];
        return r;
    endfunction

    // Cycle-level model state.
    bit           m_busy = 0, m_done = 0;
    int           m_cnt = 0, m_tgt = 0;
    logic [255:0] m_work = '0, m_out = '0;

    // Model update on each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_tgt = 0;
            m_work = '0; m_out = '0;
        end else begin
            m_done = 0;
            if (start_i && !m_busy) begin
                m_cnt = 0; m_tgt = int'(steps_i); m_work = state_i;
                if (steps_i == 0) begin
                    m_done = 1; m_out = state_i;
                end else begin
                    m_busy = 1;
                end
            end else if (m_busy) begin
                m_work = ref_step(m_work, m_cnt);
                m_cnt++;
                if (m_cnt == m_tgt) begin
                    m_busy = 0; m_done = 1; m_out = m_work;
                end
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(phase, "busy_o (R7)", 256'(busy_o), 256'(m_busy));
            check(phase, "done_o (R6)", 256'(done_o), 256'(m_done));
            check(phase, "state_o (R9)", state_o, m_out);
        end
    end

    function automatic logic [255:0] rnd_state();
        logic [255:0] s;
        for (int i = 0; i < 8; i++) s[32*i +: 32] = $urandom;
        return s;
    endfunction

    // Issue one start and wait for completion.
    task automatic run_op(input int n, input logic [255:0] s);
        @(negedge clk);
        start_i = 1'b1; steps_i = 4'(n); state_i = s;
        @(negedge clk);
        start_i = 1'b0; state_i = rnd_state();
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        logic [255:0] s0;
        repeat (3) @(negedge clk);
        phase = "R1";
        check("R1", "busy_o in reset", 256'(busy_o), 256'(0));
        check("R1", "done_o in reset", 256'(done_o), 256'(0));
        check("R1", "state_o in reset", state_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "state_o after reset", state_o, '0);

        phase = "R8";
        s0 = rnd_state();
        run_op(0, s0);
        check("R8", "zero-step pass-through", state_o, s0);

        phase = "R2/R3/R4/R5";
        run_op(1, '0);
        run_op(1, {8{32'hFFFF0000}});
        run_op(3, rnd_state());

        phase = "R6/R10";
        run_op(8, rnd_state());
        run_op(9, rnd_state());
        run_op(15, rnd_state());

        phase = "R9";
        s0 = state_o;
        repeat (5) @(negedge clk);
        check("R9", "state_o held while idle", state_o, s0);

        phase = "R7";
        @(negedge clk);
        start_i = 1'b1; steps_i = 4'd10; state_i = rnd_state();
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1; steps_i = 4'd0; state_i = rnd_state();
        @(negedge clk);
        start_i = 1'b0;
        check("R7", "start ignored while busy", 256'(busy_o), 256'(1));
        while (!busy_o || uut.busy_o === 1'bx) @(negedge clk);
        while (busy_o) begin
            start_i = 1'b1; steps_i = 4'd2; state_i = rnd_state();
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R7", "done after ignored starts", 256'(done_o), 256'(1));

        phase = "R6";
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            start_i = 1'b1; steps_i = 4'($urandom_range(0, 15)); state_i = rnd_state();
            @(negedge clk);
            start_i = 1'b0;
            while (!done_o) @(negedge clk);
            start_i = 1'b1; steps_i = 4'($urandom_range(0, 4)); state_i = rnd_state();
            @(negedge clk);
            start_i = 1'b0;
            while (busy_o) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule